// File: doc/BRIEF.md
# Register-Stepped I2C Master Controller

This block is the software-facing half of an I2C master. A processor steps it through a bank of byte-wide registers: it sets control bits to open or close a transfer, writes the data register to send an address or a payload byte, and reads the data register to pull the next received byte. After each step a five-bit phase code, stored in the upper bits of the status register, tells software what happened. An interrupt flag in the control register marks that a phase has finished. When the enable bit is also set, the flag drives the interrupt output.

Bus activity leaves the block as abstract byte-level requests: open with address and direction, send byte, receive byte, close. Each request is a hold-until-response handshake. A lower bit-timing engine, or the bench's responder model, returns acknowledge or not-acknowledge and, for a receive, the byte. A register access that starts a bus request stalls until that request completes. A soft-reset bit freezes control and data writes while it is set. Releasing it restores every register to its reset value.

Top module: `i2c_reg_master`

## Requirements
- R1: After reset the status register reads 0xF8 (idle code 0x1F in bits 7:3), the line register reads 0x3A, and every other register reads 0x00. A read of an offset outside 0x00..0x20, or one that is not a multiple of 4, returns 0x00.
- R2: Writes keep only these bits: clock 0x7F (offset 0x14), soft reset 0x01 (0x18), feature 0x03 (0x1C) and line 0x3F (0x20). The address register (0x00) and the extended address register (0x04) keep all 8 bits.
- R3: The control register is at 0x0C, with bit 7 interrupt enable, bit 6 bus enable, bit 5 start, bit 4 stop, bit 3 flag and bit 2 acknowledge-enable. Writes are masked with 0xFC. A start moves the status to 0x08 from idle and to 0x10 from any other code. A stop issues a close request (kind 3) and returns the status to idle. Start and stop always read back as 0.
- R4: A data write (offset 0x08) in status 0x08 or 0x10 issues an open request (kind 0) carrying the byte, with the address in bits 7:1 and read/write in bit 0. Not-acknowledge gives status 0x20. Acknowledge gives 0x40 when bit 0 is 1, 0x18 when it is 0, and raises the flag.
- R5: A data write in status 0x18 or 0x28 issues a send request (kind 1). Acknowledge gives 0x28 and raises the flag. Not-acknowledge gives 0x30 and is followed at once by a close request. A data write in any other status issues no request.
- R6: A data read in status 0x40, 0x50 or 0x58 issues a receive request (kind 2). The read returns the received byte. The status becomes 0x50 if acknowledge-enable is set, otherwise 0x58, and the flag is raised. A status read in 0x40 returns 0x40 and makes the same advance without a bus request.
- R7: A phase completion or control write raises the flag only while soft reset is clear, bus enable is set and the status is not idle. The interrupt output equals flag AND interrupt enable.
- R8: Parameter CLR_ON_ONE selects how the flag is cleared. With 0, the flag takes the written bit 3, so writing 0 clears it. With 1, any control write clears it.
- R9: A control write with acknowledge-enable clear turns status 0x50 into 0x58. A control write with it set turns 0x58 into 0x50.
- R10: Control writes are ignored while soft reset is set. Data writes are ignored while soft reset is set or bus enable is clear: the status, the data register and the bus are untouched.
- R11: Writing 0 to the soft reset bit while it is 1 returns every register to its reset value. A close request is issued if the status was not idle.
- R12: An access that needs no bus request is acknowledged one cycle after it is accepted. An access that issues a request holds the request and its fields steady until the response, and is acknowledged the cycle after the last response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request, held until reg_ack |
| reg_we | input | 1 | 1 write, 0 read |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_ack is high |
| reg_ack | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Interrupt: flag AND interrupt enable |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_kind | output | 2 | 0 open, 1 send, 2 receive, 3 close |
| bus_req_byte | output | 8 | Address byte or payload byte |
| bus_rsp_valid | input | 1 | Response strobe; completes the pending request |
| bus_rsp_nack | input | 1 | 1 when the target did not acknowledge |
| bus_rsp_byte | input | 8 | Received byte for a receive request |

## Verification
A local register access updates state on the edge that accepts it. Its read data and acknowledge appear one cycle later. A bus-backed access raises bus_req_valid one cycle after acceptance. It completes on the edge where the response strobe is seen, so the acknowledge comes exactly two cycles more than the responder's delay after the request. The bench drives each access at a falling edge and waits for the acknowledge. It reads results and the interrupt at falling edges, after all register updates have settled. It measures the access latency in cycles and compares it with one cycle for local accesses and with the responder delay plus two for bus accesses.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam int BYTE_W = 8;
  localparam int CODE_W = 5;

  typedef enum logic [1:0] {
    BK_OPEN  = 2'd0,
    BK_SEND  = 2'd1,
    BK_RECV  = 2'd2,
    BK_CLOSE = 2'd3
  } bus_kind_t;

  // register selects (word index of the byte offset)
  localparam logic [3:0] RS_ADDR  = 4'd0;
  localparam logic [3:0] RS_XADDR = 4'd1;
  localparam logic [3:0] RS_DATA  = 4'd2;
  localparam logic [3:0] RS_CTRL  = 4'd3;
  localparam logic [3:0] RS_STAT  = 4'd4;
  localparam logic [3:0] RS_CLK   = 4'd5;
  localparam logic [3:0] RS_SRST  = 4'd6;
  localparam logic [3:0] RS_FEAT  = 4'd7;
  localparam logic [3:0] RS_LINE  = 4'd8;
  localparam logic [3:0] RS_NONE  = 4'hF;
  localparam int         RS_COUNT = 9;

  // control bit positions
  localparam int CB_IE   = 7;
  localparam int CB_BUS  = 6;
  localparam int CB_STA  = 5;
  localparam int CB_STP  = 4;
  localparam int CB_FLAG = 3;
  localparam int CB_AA   = 2;

  localparam logic [BYTE_W-1:0] CTRL_KEEP = 8'hFC;
  localparam logic [BYTE_W-1:0] CLK_KEEP  = 8'h7F;
  localparam logic [BYTE_W-1:0] FEAT_KEEP = 8'h03;
  localparam logic [BYTE_W-1:0] LINE_KEEP = 8'h3F;
  localparam logic [BYTE_W-1:0] LINE_INIT = 8'h3A;

  // phase codes (status register bits 7:3)
  localparam logic [CODE_W-1:0] PH_IDLE      = 5'h1F;
  localparam logic [CODE_W-1:0] PH_OPENED    = 5'h01;
  localparam logic [CODE_W-1:0] PH_REOPENED  = 5'h02;
  localparam logic [CODE_W-1:0] PH_WADR_ACK  = 5'h03;
  localparam logic [CODE_W-1:0] PH_WADR_NAK  = 5'h04;
  localparam logic [CODE_W-1:0] PH_TX_ACK    = 5'h05;
  localparam logic [CODE_W-1:0] PH_TX_NAK    = 5'h06;
  localparam logic [CODE_W-1:0] PH_RADR_ACK  = 5'h08;
  localparam logic [CODE_W-1:0] PH_RX_ACK    = 5'h0A;
  localparam logic [CODE_W-1:0] PH_RX_NAK    = 5'h0B;

  function automatic logic [BYTE_W-1:0] set_flag(input logic [BYTE_W-1:0] c,
                                                 input logic [CODE_W-1:0] code,
                                                 input logic held);
    set_flag = c;
    if (!held && c[CB_BUS] && (code != PH_IDLE)) set_flag[CB_FLAG] = 1'b1;
  endfunction

endpackage

// File: rtl/i2cm_bus_port.sv
module i2cm_bus_port
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  bus_kind_t         issue_kind,
  input  logic [BYTE_W-1:0] issue_byte,
  output logic              req_valid,
  output bus_kind_t         req_kind,
  output logic [BYTE_W-1:0] req_byte,
  input  logic              rsp_valid,
  input  logic              rsp_nack,
  input  logic [BYTE_W-1:0] rsp_byte,
  output logic              done,
  output logic              done_nack,
  output logic [BYTE_W-1:0] done_byte
);

  logic              valid_q, valid_d;
  bus_kind_t         kind_q, kind_d;
  logic [BYTE_W-1:0] byte_q, byte_d;

  assign done      = valid_q & rsp_valid;
  assign done_nack = rsp_nack;
  assign done_byte = rsp_byte;

  always_comb begin
    valid_d = valid_q;
    kind_d  = kind_q;
    byte_d  = byte_q;
    if (done) valid_d = 1'b0;
    if (issue) begin
      valid_d = 1'b1;
      kind_d  = issue_kind;
      byte_d  = issue_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      kind_q  <= BK_CLOSE;
      byte_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (issue) begin
        kind_q <= kind_d;
        byte_q <= byte_d;
      end
    end
  end

  assign req_valid = valid_q;
  assign req_kind  = kind_q;
  assign req_byte  = byte_q;

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !rsp_valid) |=> (valid_q && $stable(kind_q) && $stable(byte_q)))
    else $error("bus request changed before its response");

endmodule

// File: rtl/i2cm_core.sv
module i2cm_core
  import i2cm_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter bit CLR_ON_ONE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              reg_ack,
  output logic              irq,
  output logic              issue,
  output bus_kind_t         issue_kind,
  output logic [BYTE_W-1:0] issue_byte,
  input  logic              bus_done,
  input  logic              bus_done_nack,
  input  logic [BYTE_W-1:0] bus_done_byte
);

  localparam int IDX_W = ADDR_W - 2;

  typedef enum logic {P_READY = 1'b0, P_WAIT = 1'b1} phase_t;

  logic [BYTE_W-1:0] addr_q, addr_d, xaddr_q, xaddr_d, data_q, data_d;
  logic [BYTE_W-1:0] ctrl_q, ctrl_d, clk_q, clk_d, feat_q, feat_d, line_q, line_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              srst_q, srst_d;
  logic [BYTE_W-1:0] rdata_q, rdata_d;
  logic              ack_q, ack_d;
  phase_t            ph_q, ph_d;
  bus_kind_t         pend_q, pend_d;

  logic [3:0]        sel;
  logic [IDX_W-1:0]  idx;
  logic              accept;
  logic [CODE_W-1:0] rx_code;

  logic [BYTE_W-1:0] cw_ctrl;
  logic [CODE_W-1:0] cw_code;
  logic              cw_stop;

  assign idx     = reg_addr[ADDR_W-1:2];
  assign accept  = (ph_q == P_READY) && reg_req && !ack_q;
  assign rx_code = ctrl_q[CB_AA] ? PH_RX_ACK : PH_RX_NAK;

  always_comb begin
    sel = RS_NONE;
    if ((reg_addr[1:0] == 2'b00) && (32'(idx) < RS_COUNT)) sel = 4'(idx);
  end

  // effect of a control-register write
  always_comb begin
    cw_ctrl = reg_wdata & CTRL_KEEP;
    cw_code = code_q;
    cw_stop = 1'b0;
    if (cw_ctrl[CB_STA]) begin
      cw_code = (code_q == PH_IDLE) ? PH_OPENED : PH_REOPENED;
      cw_ctrl[CB_STA] = 1'b0;
    end
    if (cw_ctrl[CB_STP]) begin
      cw_stop = 1'b1;
      cw_code = PH_IDLE;
      cw_ctrl[CB_STP] = 1'b0;
    end
    if (CLR_ON_ONE) cw_ctrl[CB_FLAG] = 1'b0;
    if (!cw_ctrl[CB_AA] && (cw_code == PH_RX_ACK))     cw_code = PH_RX_NAK;
    else if (cw_ctrl[CB_AA] && (cw_code == PH_RX_NAK)) cw_code = PH_RX_ACK;
    cw_ctrl = set_flag(cw_ctrl, cw_code, 1'b0);
  end

  always_comb begin
    addr_d = addr_q;  xaddr_d = xaddr_q; data_d = data_q; ctrl_d = ctrl_q;
    clk_d  = clk_q;   feat_d  = feat_q;  line_d = line_q; code_d = code_q;
    srst_d = srst_q;  rdata_d = rdata_q; ph_d   = ph_q;   pend_d = pend_q;
    ack_d      = 1'b0;
    issue      = 1'b0;
    issue_kind = BK_CLOSE;
    issue_byte = reg_wdata;
    case (ph_q)
      P_READY: begin
        if (accept) begin
          if (reg_we) begin
            case (sel)
              RS_ADDR:  addr_d  = reg_wdata;
              RS_XADDR: xaddr_d = reg_wdata;
              RS_CLK:   clk_d   = reg_wdata & CLK_KEEP;
              RS_FEAT:  feat_d  = reg_wdata & FEAT_KEEP;
              RS_LINE:  line_d  = reg_wdata & LINE_KEEP;
              RS_SRST: begin
                srst_d = reg_wdata[0];
                if (!reg_wdata[0] && srst_q) begin
                  addr_d = '0; xaddr_d = '0; data_d = '0; ctrl_d = '0;
                  clk_d  = '0; feat_d  = '0; line_d = LINE_INIT;
                  code_d = PH_IDLE;
                  if (code_q != PH_IDLE) begin
                    issue = 1'b1; issue_kind = BK_CLOSE;
                  end
                end
              end
              RS_CTRL: begin
                if (!srst_q) begin
                  ctrl_d = cw_ctrl;
                  code_d = cw_code;
                  if (cw_stop) begin
                    issue = 1'b1; issue_kind = BK_CLOSE;
                  end
                end
              end
              RS_DATA: begin
                if (!srst_q && ctrl_q[CB_BUS]) begin
                  data_d = reg_wdata;
                  if ((code_q == PH_OPENED) || (code_q == PH_REOPENED)) begin
                    issue = 1'b1; issue_kind = BK_OPEN;
                  end else if ((code_q == PH_WADR_ACK) || (code_q == PH_TX_ACK)) begin
                    issue = 1'b1; issue_kind = BK_SEND;
                  end
                end
              end
              default: ;
            endcase
          end else begin
            case (sel)
              RS_ADDR:  rdata_d = addr_q;
              RS_XADDR: rdata_d = xaddr_q;
              RS_CTRL:  rdata_d = ctrl_q;
              RS_CLK:   rdata_d = clk_q;
              RS_SRST:  rdata_d = {7'd0, srst_q};
              RS_FEAT:  rdata_d = feat_q;
              RS_LINE:  rdata_d = line_q;
              RS_STAT: begin
                rdata_d = {code_q, 3'b000};
                if (code_q == PH_RADR_ACK) begin
                  code_d = rx_code;
                  ctrl_d = set_flag(ctrl_q, rx_code, srst_q);
                end
              end
              RS_DATA: begin
                rdata_d = data_q;
                if ((code_q == PH_RADR_ACK) || (code_q == PH_RX_ACK) ||
                    (code_q == PH_RX_NAK)) begin
                  issue = 1'b1; issue_kind = BK_RECV;
                end
              end
              default: rdata_d = '0;
            endcase
          end
          if (issue) begin
            ph_d   = P_WAIT;
            pend_d = issue_kind;
          end else begin
            ack_d = 1'b1;
          end
        end
      end
      P_WAIT: begin
        if (bus_done) begin
          ph_d  = P_READY;
          ack_d = 1'b1;
          case (pend_q)
            BK_OPEN: begin
              if (bus_done_nack) code_d = PH_WADR_NAK;
              else begin
                code_d = data_q[0] ? PH_RADR_ACK : PH_WADR_ACK;
                ctrl_d = set_flag(ctrl_q, code_d, srst_q);
              end
            end
            BK_SEND: begin
              if (bus_done_nack) begin
                code_d     = PH_TX_NAK;
                issue      = 1'b1;
                issue_kind = BK_CLOSE;
                pend_d     = BK_CLOSE;
                ph_d       = P_WAIT;
                ack_d      = 1'b0;
              end else begin
                code_d = PH_TX_ACK;
                ctrl_d = set_flag(ctrl_q, PH_TX_ACK, srst_q);
              end
            end
            BK_RECV: begin
              data_d  = bus_done_byte;
              rdata_d = bus_done_byte;
              code_d  = rx_code;
              ctrl_d  = set_flag(ctrl_q, rx_code, srst_q);
            end
            default: ;
          endcase
        end
      end
      default: ph_d = P_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0; xaddr_q <= '0; data_q <= '0; ctrl_q <= '0;
      clk_q  <= '0; feat_q  <= '0; line_q <= LINE_INIT;
      code_q <= PH_IDLE; srst_q <= 1'b0; rdata_q <= '0; ack_q <= 1'b0;
      ph_q   <= P_READY; pend_q <= BK_CLOSE;
    end else begin
      addr_q <= addr_d; xaddr_q <= xaddr_d; data_q <= data_d; ctrl_q <= ctrl_d;
      clk_q  <= clk_d;  feat_q  <= feat_d;  line_q <= line_d;
      code_q <= code_d; srst_q  <= srst_d;  rdata_q <= rdata_d; ack_q <= ack_d;
      ph_q   <= ph_d;   pend_q  <= pend_d;
    end
  end

  assign reg_rdata = rdata_q;
  assign reg_ack   = ack_q;
  assign irq       = ctrl_q[CB_FLAG] & ctrl_q[CB_IE];

  // R12
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q)
    else $error("register acknowledge longer than one cycle");

  // R7
  flag_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == P_WAIT) && bus_done && !srst_q && ctrl_q[CB_BUS] &&
     ((pend_q == BK_RECV) || (!bus_done_nack && (pend_q == BK_OPEN || pend_q == BK_SEND))))
    |=> ctrl_q[CB_FLAG])
    else $error("completed phase did not raise the flag");

  // R11
  srst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srst_q) |-> ((code_q == PH_IDLE) && (ctrl_q == '0) && (line_q == LINE_INIT)))
    else $error("soft reset release left state behind");

endmodule

// File: rtl/i2c_reg_master.sv
module i2c_reg_master
  import i2cm_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter bit CLR_ON_ONE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              reg_ack,
  output logic              irq,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_kind,
  output logic [7:0]        bus_req_byte,
  input  logic              bus_rsp_valid,
  input  logic              bus_rsp_nack,
  input  logic [7:0]        bus_rsp_byte
);

  logic              issue;
  bus_kind_t         issue_kind;
  logic [BYTE_W-1:0] issue_byte;
  logic              done, done_nack;
  logic [BYTE_W-1:0] done_byte;
  bus_kind_t         req_kind;

  i2cm_core #(.ADDR_W(ADDR_W), .CLR_ON_ONE(CLR_ON_ONE)) u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_req       (reg_req),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .reg_ack       (reg_ack),
    .irq           (irq),
    .issue         (issue),
    .issue_kind    (issue_kind),
    .issue_byte    (issue_byte),
    .bus_done      (done),
    .bus_done_nack (done_nack),
    .bus_done_byte (done_byte)
  );

  i2cm_bus_port u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .issue_kind (issue_kind),
    .issue_byte (issue_byte),
    .req_valid  (bus_req_valid),
    .req_kind   (req_kind),
    .req_byte   (bus_req_byte),
    .rsp_valid  (bus_rsp_valid),
    .rsp_nack   (bus_rsp_nack),
    .rsp_byte   (bus_rsp_byte),
    .done       (done),
    .done_nack  (done_nack),
    .done_byte  (done_byte)
  );

  assign bus_req_kind = req_kind;

  // R12
  ack_after_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ack |-> !bus_req_valid)
    else $error("access acknowledged while a bus request is pending");

endmodule

// File: tb/i2c_reg_master_tb.sv
module i2c_reg_master_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RESP_DELAY = 3;
  localparam int N_VEC      = 27;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_req, reg_we;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       reg_ack, irq;
  logic       bus_req_valid;
  logic [1:0] bus_req_kind;
  logic [7:0] bus_req_byte;
  logic       bus_rsp_valid, bus_rsp_nack;
  logic [7:0] bus_rsp_byte;

  int checks = 0;
  int errors = 0;
  int n_open = 0, n_send = 0, n_recv = 0, n_close = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_ack(reg_ack), .irq(irq), .bus_req_valid(bus_req_valid),
    .bus_req_kind(bus_req_kind), .bus_req_byte(bus_req_byte),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_nack(bus_rsp_nack),
    .bus_rsp_byte(bus_rsp_byte)
  );

  typedef struct packed {
    logic       we;
    logic [5:0] a;
    logic [7:0] v;
    logic [3:0] rq;
  } vec_t;

  localparam vec_t VT [N_VEC] = '{
    '{1'b0, 6'h0C, 8'h00, 4'd1},   // R1 control
    '{1'b0, 6'h10, 8'hF8, 4'd1},   // R1 status idle
    '{1'b0, 6'h20, 8'h3A, 4'd1},   // R1 line
    '{1'b0, 6'h14, 8'h00, 4'd1},   // R1 clock
    '{1'b1, 6'h14, 8'hFF, 4'd2},
    '{1'b0, 6'h14, 8'h7F, 4'd2},   // R2
    '{1'b1, 6'h1C, 8'hFF, 4'd2},
    '{1'b0, 6'h1C, 8'h03, 4'd2},   // R2
    '{1'b1, 6'h20, 8'hFF, 4'd2},
    '{1'b0, 6'h20, 8'h3F, 4'd2},   // R2
    '{1'b1, 6'h00, 8'hA5, 4'd2},
    '{1'b0, 6'h00, 8'hA5, 4'd2},   // R2
    '{1'b1, 6'h04, 8'h3C, 4'd2},
    '{1'b0, 6'h04, 8'h3C, 4'd2},   // R2
    '{1'b0, 6'h24, 8'h00, 4'd1},   // R1 out of range
    '{1'b0, 6'h0D, 8'h00, 4'd1},   // R1 misaligned
    '{1'b1, 6'h0C, 8'hFF, 4'd3},   // start and stop together
    '{1'b0, 6'h0C, 8'hCC, 4'd3},   // R3 start/stop self-clear
    '{1'b0, 6'h10, 8'hF8, 4'd3},   // R3 stop wins
    '{1'b1, 6'h0C, 8'h00, 4'd3},
    '{1'b0, 6'h0C, 8'h00, 4'd3},   // R3
    '{1'b1, 6'h18, 8'hFF, 4'd2},
    '{1'b0, 6'h18, 8'h01, 4'd2},   // R2 soft reset mask
    '{1'b1, 6'h18, 8'h00, 4'd11},
    '{1'b0, 6'h14, 8'h00, 4'd11},  // R11 clock restored
    '{1'b0, 6'h20, 8'h3A, 4'd11},  // R11 line restored
    '{1'b0, 6'h00, 8'h00, 4'd11}   // R11 address restored
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [5:0] a, input logic [7:0] d,
                     output logic [7:0] rd, output int cyc);
    @(negedge clk);
    reg_req = 1'b1; reg_we = we; reg_addr = a; reg_wdata = d;
    cyc = 0;
    do begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end while (!reg_ack && cyc < 2000);
    rd = reg_rdata;
    reg_req = 1'b0;
    if (cyc >= 2000) chk("R12 access timeout", cyc, 0);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    logic [7:0] rd;
    int cyc;
    acc(1'b1, a, d, rd, cyc);
  endtask

  task automatic rdchk(input string req, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] rd;
    int cyc;
    acc(1'b0, a, 8'h00, rd, cyc);
    chk(req, rd, exp);
  endtask

  // bus responder: open acks only address 0x50, send nacks byte 0xEE
  initial begin
    bus_rsp_valid = 1'b0; bus_rsp_nack = 1'b0; bus_rsp_byte = 8'h00;
    forever begin
      @(negedge clk);
      if (bus_req_valid) begin
        repeat (RESP_DELAY) @(negedge clk);
        bus_rsp_nack = 1'b0;
        case (bus_req_kind)
          2'd0: begin bus_rsp_nack = (bus_req_byte[7:1] != 7'h50); n_open++; end
          2'd1: begin bus_rsp_nack = (bus_req_byte == 8'hEE); n_send++; end
          2'd2: begin bus_rsp_byte = 8'h30 + 8'(n_recv); n_recv++; end
          default: n_close++;
        endcase
        bus_rsp_valid = 1'b1;
        @(negedge clk);
        bus_rsp_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int cyc, c0;
    rst_n = 1'b0; reg_req = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 irq after reset", irq, 0);
    chk("R1 no bus request after reset", bus_req_valid, 0);

    for (int i = 0; i < N_VEC; i++) begin
      if (VT[i].we) wr(VT[i].a, VT[i].v);
      else begin
        acc(1'b0, VT[i].a, 8'h00, rd, cyc);
        chk($sformatf("R%0d table entry %0d", VT[i].rq, i), rd, VT[i].v);
      end
    end
    chk("R3 stop issued a close", n_close, 1);

    // write transfer
    wr(6'h0C, 8'h64);
    rdchk("R3 start from idle, R7 flag", 6'h0C, 8'h4C);
    rdchk("R3 status after start", 6'h10, 8'h08);
    chk("R7 irq gated by enable", irq, 0);
    wr(6'h08, 8'hA0);
    rdchk("R4 write address acked", 6'h10, 8'h18);
    chk("R4 open request count", n_open, 1);
    wr(6'h08, 8'h11);
    rdchk("R5 byte sent with ack", 6'h10, 8'h28);
    wr(6'h08, 8'hEE);
    rdchk("R5 byte sent without ack", 6'h10, 8'h30);
    chk("R5 close after send nack", n_close, 2);
    chk("R5 send count", n_send, 2);
    wr(6'h08, 8'h22);
    chk("R5 no request outside send phases", n_send, 2);

    // read transfer via repeated start
    wr(6'h0C, 8'hE4);
    rdchk("R3 repeated start", 6'h10, 8'h10);
    chk("R7 irq with enable", irq, 1);
    wr(6'h08, 8'hA1);
    rdchk("R6 status read in 0x40", 6'h10, 8'h40);
    rdchk("R6 status read advanced", 6'h10, 8'h50);
    acc(1'b0, 6'h08, 8'h00, rd, cyc);
    chk("R6 first received byte", rd, 8'h30);
    chk("R12 bus access latency", cyc, RESP_DELAY + 2);
    acc(1'b0, 6'h14, 8'h00, rd, cyc);
    chk("R12 local access latency", cyc, 1);
    wr(6'h0C, 8'hC0);
    rdchk("R9 ack disable 0x50 to 0x58", 6'h10, 8'h58);
    rdchk("R6 second received byte", 6'h08, 8'h31);
    rdchk("R6 status without ack", 6'h10, 8'h58);
    wr(6'h0C, 8'hC4);
    rdchk("R9 ack enable 0x58 to 0x50", 6'h10, 8'h50);
    wr(6'h0C, 8'hD0);
    rdchk("R3 stop clears itself", 6'h0C, 8'hC0);
    rdchk("R3 stop returns idle", 6'h10, 8'hF8);
    chk("R3 stop close count", n_close, 3);
    chk("R7 irq low after flag write 0", irq, 0);

    // address not acknowledged
    wr(6'h0C, 8'h60);
    wr(6'h08, 8'h42);
    rdchk("R4 address nack", 6'h10, 8'h20);
    wr(6'h0C, 8'h50);

    // data write with bus disabled
    wr(6'h0C, 8'h00);
    c0 = n_open;
    wr(6'h08, 8'h77);
    rdchk("R10 data reg untouched with bus off", 6'h08, 8'h42);
    chk("R10 no request with bus off", n_open, c0);

    // flag needs bus enable
    wr(6'h0C, 8'h20);
    rdchk("R7 no flag with bus off", 6'h0C, 8'h00);
    rdchk("R3 start with bus off", 6'h10, 8'h08);

    // soft reset hold and release
    wr(6'h18, 8'h01);
    wr(6'h0C, 8'h50);
    rdchk("R10 control ignored in soft reset", 6'h10, 8'h08);
    wr(6'h08, 8'h99);
    rdchk("R10 data ignored in soft reset", 6'h08, 8'h42);
    c0 = n_close;
    wr(6'h18, 8'h00);
    chk("R11 close on release when active", n_close, c0 + 1);
    rdchk("R11 status idle", 6'h10, 8'hF8);
    rdchk("R11 data cleared", 6'h08, 8'h00);

    // flag clear polarity, default mode
    wr(6'h0C, 8'h08);
    rdchk("R8 flag follows written one", 6'h0C, 8'h08);
    wr(6'h0C, 8'h88);
    chk("R8 irq with flag and enable", irq, 1);
    wr(6'h0C, 8'h80);
    rdchk("R8 write zero clears flag", 6'h0C, 8'h80);
    chk("R8 irq dropped", irq, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule